// File: doc/BRIEF.md
# JTAG Port Owner Switch with Primary TAP

This block holds a primary IEEE 1149.1 test access port controller together with the logic that decides which of two controllers owns the chip's JTAG pins. After power-on the primary TAP owns the port. It provides the standard 16-state state machine, a 4-bit instruction register, a one-bit bypass path and a 32-bit identification register. A second, lower-level debug TAP sits behind the block. The block passes TMS and TDI on to that TAP and, once the TAP is chosen, returns its TDO on the chip pin.

The secondary TAP can be selected in two ways. In the first, the debug-event pin is held low for two successive TCK rising edges while the primary state machine rests in Test-Logic-Reset and TRST is high. In the second, the instruction code 4'b0011 is scanned into the instruction register, and the handover takes effect when the state machine passes Update-IR. The choice is sticky. From then on the primary TAP is frozen and ignores TMS and TDI. Only TRST low or power-on reset gives the port back to it.

Top module: `jtag_port_switch`

## Requirements
- R1: After `por` (active high, sampled at the TCK rising edge), `sec_sel` is 0, `tdo_oe` is 0, `sec_tms` is 1, the state machine is in Test-Logic-Reset and the active instruction is IDCODE (4'b0001).
- R2: The state machine follows the 1149.1 transition graph on TCK rising edges. Five rising edges with TMS high reach Test-Logic-Reset from any state, and that state reloads the IDCODE instruction.
- R3: Capture-IR loads 4'b0001 into the instruction shift register. Shift-IR moves it out on TDO LSB first while TDI enters at the MSB, and Update-IR makes the shifted value the active instruction.
- R4: With instruction 4'b0001 active, Capture-DR loads the 32-bit identification value, whose bit 0 is always 1. Shift-DR returns it LSB first.
- R5: Instruction 4'b1111, and every code other than 4'b0001, selects a one-bit bypass register. This register captures 0 in Capture-DR and delays TDI by one shift.
- R6: The primary TDO and `tdo_oe` change on the TCK falling edge. `tdo_oe` is high only while the state is Shift-IR or Shift-DR.
- R7: When the state machine passes Update-IR with 4'b0011 in the instruction shift register, `sec_sel` goes to 1.
- R8: If `dbg_evt_n` is low at two consecutive TCK rising edges while the state is Test-Logic-Reset and `trst_n` is high, `sec_sel` goes to 1 at the second edge. A single low edge does nothing, and low edges in any other state do nothing.
- R9: While `sec_sel` is 1, the primary state machine and its registers hold their values. `tdo` equals `sec_tdo`, `tdo_oe` is 1 and `sec_tms` follows `tms`. While `sec_sel` is 0, `sec_tms` is held at 1.
- R10: `sec_sel` stays set until `trst_n` is low at a TCK rising edge or `por` is asserted. That same edge resets the primary TAP to Test-Logic-Reset with IDCODE active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-on reset, active high, synchronous to tck |
| trst_n | input | 1 | Test reset, active low, sampled on the tck rising edge |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| dbg_evt_n | input | 1 | Debug-event request, active low |
| sec_tdo | input | 1 | Data out of the secondary TAP |
| tdo | output | 1 | Test data out to the pin |
| tdo_oe | output | 1 | Output enable for tdo |
| sec_sel | output | 1 | Secondary TAP owns the port |
| sec_tms | output | 1 | TMS forwarded to the secondary TAP |
| sec_tdi | output | 1 | TDI forwarded to the secondary TAP |

## Verification
The data-register path is scanned under three instructions: the default IDCODE, explicit BYPASS and an undefined code. The 32-bit identification pattern, the captured zero of the bypass register and the one-shift delay of TDI show which register the instruction decoder chose. The handover is exercised in both directions. Path B is a scanned code. Path A is a debug-event pulse of one edge, three low edges outside Test-Logic-Reset and two low edges inside it, and these separate correct qualification from a simple level detector. During the lockout, TMS sequences that would normally move the state machine are applied, and TDO is checked against an inverting stub. After a TRST pulse a fresh IDCODE scan shows that the primary TAP has returned to its reset state.

// File: rtl/jtag_sel_pkg.sv
package jtag_sel_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_t;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_sel_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    hold,
  input  logic    tms,
  output tap_st_t state
);
  tap_st_t nxt;

  always_comb begin
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst)        state <= ST_TLR;
    else if (!hold) state <= nxt;
  end

  // R9: frozen while the secondary TAP owns the port
  a_r9_frozen: assert property (@(posedge tck) disable iff (rst)
    hold |=> $stable(state));
  // R2: TMS high in Test-Logic-Reset stays there
  a_r2_tlr_hold: assert property (@(posedge tck) disable iff (rst)
    (state == ST_TLR && tms) |=> (state == ST_TLR));
endmodule

// File: rtl/tap_regs.sv
module tap_regs
  import jtag_sel_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int ID_W = 32,
  parameter logic [ID_W-1:0] ID_VAL   = 32'h0F1E_2D3B,
  parameter logic [IR_W-1:0] IDC_CODE = 4'b0001,
  parameter logic [IR_W-1:0] CAP_PAT  = 4'b0001
)(
  input  logic            tck,
  input  logic            rst,
  input  logic            hold,
  input  logic            tdi,
  input  tap_st_t         state,
  output logic [IR_W-1:0] ir_shift,
  output logic            top_tdo,
  output logic            top_oe
);
  localparam logic [ID_W-1:0] ID_FIX = {ID_VAL[ID_W-1:1], 1'b1};

  logic [IR_W-1:0] ir_act;
  logic [ID_W-1:0] id_sh;
  logic            byp;
  logic            id_sel;

  assign id_sel = (ir_act == IDC_CODE);

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_act   <= IDC_CODE;
      ir_shift <= CAP_PAT;
      id_sh    <= ID_FIX;
      byp      <= 1'b0;
    end else if (!hold) begin
      case (state)
        ST_TLR:    ir_act   <= IDC_CODE;
        ST_CAP_IR: ir_shift <= CAP_PAT;
        ST_SHF_IR: ir_shift <= {tdi, ir_shift[IR_W-1:1]};
        ST_UPD_IR: ir_act   <= ir_shift;
        ST_CAP_DR: begin
          if (id_sel) id_sh <= ID_FIX;
          else        byp   <= 1'b0;
        end
        ST_SHF_DR: begin
          if (id_sel) id_sh <= {tdi, id_sh[ID_W-1:1]};
          else        byp   <= tdi;
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck) begin
    if (rst) begin
      top_tdo <= 1'b0;
      top_oe  <= 1'b0;
    end else if (!hold) begin
      top_oe  <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
      top_tdo <= (state == ST_SHF_IR) ? ir_shift[0] : (id_sel ? id_sh[0] : byp);
    end
  end

  // R5: the bypass register captures zero
  a_r5_byp_cap: assert property (@(posedge tck) disable iff (rst)
    (!hold && state == ST_CAP_DR && !id_sel) |=> (byp == 1'b0));
  // R4: Capture-DR under IDCODE loads an odd value
  a_r4_id_lsb: assert property (@(posedge tck) disable iff (rst)
    (!hold && state == ST_CAP_DR && id_sel) |=> id_sh[0]);
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl #(
  parameter int IR_W = 4,
  parameter int EVT_EDGES = 2,
  parameter logic [IR_W-1:0] SEL_CODE = 4'b0011
)(
  input  logic            tck,
  input  logic            por,
  input  logic            trst_n,
  input  logic            dbg_evt_n,
  input  logic            in_tlr,
  input  logic            upd_ir,
  input  logic [IR_W-1:0] ir_shift,
  output logic            sel
);
  localparam int CW = $clog2(EVT_EDGES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge tck) begin
    if (por || !trst_n) begin
      cnt <= '0;
      sel <= 1'b0;
    end else begin
      if (!dbg_evt_n && in_tlr) begin
        if (cnt != CW'(EVT_EDGES)) cnt <= cnt + 1'b1;
        if (cnt == CW'(EVT_EDGES - 1)) sel <= 1'b1;
      end else begin
        cnt <= '0;
      end
      if (upd_ir && ir_shift == SEL_CODE) sel <= 1'b1;
    end
  end

  // R10: once set, only TRST or power-on reset clears the flag
  a_r10_sticky: assert property (@(posedge tck) disable iff (por)
    (sel && trst_n) |=> sel);
  a_r10_trst_clr: assert property (@(posedge tck) disable iff (por)
    !trst_n |=> !sel);
  // R7: scanned selection code at Update-IR hands the port over
  a_r7_path_b: assert property (@(posedge tck) disable iff (por || !trst_n)
    (upd_ir && ir_shift == SEL_CODE) |=> sel);
  // R8: the debug event cannot select outside Test-Logic-Reset
  a_r8_need_tlr: assert property (@(posedge tck) disable iff (por || !trst_n)
    (!sel && !in_tlr && !upd_ir) |=> !sel);
endmodule

// File: rtl/jtag_port_switch.sv
module jtag_port_switch
  import jtag_sel_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int ID_W = 32,
  parameter int EVT_EDGES = 2,
  parameter logic [ID_W-1:0] ID_VAL   = 32'h0F1E_2D3B,
  parameter logic [IR_W-1:0] IDC_CODE = 4'b0001,
  parameter logic [IR_W-1:0] SEL_CODE = 4'b0011
)(
  input  logic tck,
  input  logic por,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic dbg_evt_n,
  input  logic sec_tdo,
  output logic tdo,
  output logic tdo_oe,
  output logic sec_sel,
  output logic sec_tms,
  output logic sec_tdi
);
  tap_st_t         state;
  logic            rst;
  logic [IR_W-1:0] ir_shift;
  logic            top_tdo, top_oe;

  assign rst = por | ~trst_n;

  tap_fsm u_fsm (
    .tck(tck), .rst(rst), .hold(sec_sel), .tms(tms), .state(state)
  );

  tap_regs #(.IR_W(IR_W), .ID_W(ID_W), .ID_VAL(ID_VAL), .IDC_CODE(IDC_CODE),
             .CAP_PAT(IR_W'(1))) u_regs (
    .tck(tck), .rst(rst), .hold(sec_sel), .tdi(tdi), .state(state),
    .ir_shift(ir_shift), .top_tdo(top_tdo), .top_oe(top_oe)
  );

  sel_ctrl #(.IR_W(IR_W), .EVT_EDGES(EVT_EDGES), .SEL_CODE(SEL_CODE)) u_sel (
    .tck(tck), .por(por), .trst_n(trst_n), .dbg_evt_n(dbg_evt_n),
    .in_tlr(state == ST_TLR), .upd_ir(state == ST_UPD_IR),
    .ir_shift(ir_shift), .sel(sec_sel)
  );

  assign tdo     = sec_sel ? sec_tdo : top_tdo;
  assign tdo_oe  = sec_sel | top_oe;
  assign sec_tms = sec_sel ? tms : 1'b1;
  assign sec_tdi = tdi;

  // R9: while handed over, the pin carries the secondary TAP's data
  a_r9_route: assert property (@(posedge tck) disable iff (rst)
    sec_sel |-> (tdo == sec_tdo && tdo_oe && sec_tms == tms));
endmodule

// File: tb/jtag_port_switch_tb.sv
module jtag_port_switch_tb_top;
  localparam logic [31:0] ID_EXP = 32'h0F1E_2D3B;

  logic tck = 1'b0;
  logic por = 1'b1, trst_n = 1'b1, tms = 1'b1, tdi = 1'b0, dbg_evt_n = 1'b1;
  logic sec_tdo, tdo, tdo_oe, sec_sel, sec_tms, sec_tdi;
  logic s_tdo, s_oe;
  int   n_vec = 0, n_bad = 0;
  bit   expq[$];
  string qtag[$];

  always #5 tck = ~tck;
  assign sec_tdo = ~sec_tdi;   // secondary TAP stub

  jtag_port_switch dut_i (
    .tck(tck), .por(por), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .dbg_evt_n(dbg_evt_n), .sec_tdo(sec_tdo), .tdo(tdo), .tdo_oe(tdo_oe),
    .sec_sel(sec_sel), .sec_tms(sec_tms), .sec_tdi(sec_tdi)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic push(input string req, input bit b);
    expq.push_back(b);
    qtag.push_back(req);
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    tms = m; tdi = d;
    #4;
    s_tdo = tdo; s_oe = tdo_oe;
    @(posedge tck);
    #1;
  endtask

  // shift n bits; monitor side pops expected bits from the scoreboard
  task automatic shift_n(input int n, input logic [31:0] din);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      if (expq.size() > 0) begin
        chk(qtag.pop_front(), s_tdo, expq.pop_front());
      end
      chk("R6 oe in shift", s_oe, 1'b1);
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [3:0] code);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    push("R3", 1); push("R3", 0); push("R3", 0); push("R3", 0);
    shift_n(4, {28'd0, code});
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din);
    step(1, 0); step(0, 0); step(0, 0);
    shift_n(n, din);
  endtask

  task automatic expect_id();
    for (int i = 0; i < 32; i++) push("R4 id", ID_EXP[i]);
    dr_scan(32, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1 por = 1'b0;
    chk("R1 sel", sec_sel, 1'b0);
    chk("R1 oe", tdo_oe, 1'b0);
    chk("R1 sec_tms", sec_tms, 1'b1);
    step(0, 0);
    expect_id();                         // R1 IDCODE default, R4
    step(0, 0);
    chk("R6 oe idle", tdo_oe, 1'b0);

    load_ir(4'hF);                       // R5 bypass
    push("R5 byp", 0); push("R5 byp", 1); push("R5 byp", 0); push("R5 byp", 1);
    dr_scan(4, 32'b1101);
    load_ir(4'h5);                       // R5 undefined code
    push("R5 undef", 0); push("R5 undef", 1); push("R5 undef", 1);
    dr_scan(3, 32'b011);
    load_ir(4'h1);
    expect_id();

    load_ir(4'hF);                       // R2: TMS high resets to IDCODE
    repeat (5) step(1, 0);
    step(0, 0);
    expect_id();

    load_ir(4'h3);                       // R7 path B
    chk("R7 path B", sec_sel, 1'b1);
    for (int i = 0; i < 8; i++) begin    // R9 lockout
      step(i[0] | i[2], i[1]);
      chk("R9 tdo from secondary", s_tdo, ~tdi);
      chk("R9 oe", s_oe, 1'b1);
      chk("R9 sec_tms", sec_tms, tms);
    end
    repeat (6) step(1, 0);
    chk("R10 sticky", sec_sel, 1'b1);

    @(negedge tck); trst_n = 1'b0;       // R10 release
    @(posedge tck); #1 trst_n = 1'b1;
    chk("R10 trst clear", sec_sel, 1'b0);
    chk("R9 sec_tms idle", sec_tms, 1'b1);
    step(0, 0);
    expect_id();

    repeat (5) step(1, 0);               // R8 path A
    dbg_evt_n = 1'b0; step(1, 0);
    dbg_evt_n = 1'b1; step(1, 0);
    chk("R8 single edge", sec_sel, 1'b0);
    step(0, 0);
    dbg_evt_n = 1'b0; repeat (3) step(0, 0);
    dbg_evt_n = 1'b1;
    chk("R8 outside TLR", sec_sel, 1'b0);
    repeat (5) step(1, 0);
    dbg_evt_n = 1'b0; step(1, 0);
    chk("R8 first edge", sec_sel, 1'b0);
    step(1, 0);
    chk("R8 second edge", sec_sel, 1'b1);
    dbg_evt_n = 1'b1;

    @(negedge tck); por = 1'b1;          // R10 power-on release
    @(posedge tck); #1 por = 1'b0;
    chk("R10 por clear", sec_sel, 1'b0);
    chk("R1 oe after por", tdo_oe, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule